// File: doc/BRIEF.md
# Perceptron Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a small table of perceptrons and picks one by branch address. Each perceptron holds a bias weight and one signed weight for each bit of a global outcome history. To predict, the block works out the weighted sum of the history. Each history bit counts as +1 when that branch was taken and -1 when it was not. The sign of the sum is the guess, and the sum itself is returned as a confidence score. Storage grows by one weight per extra history bit, so a long history costs little compared with a table of pattern counters.

A prediction request is answered in the next cycle. A resolved branch is reported through the update port. The control state machine has two states:

- **S_IDLE** waits for an update. On the transition *accept* (update valid in S_IDLE), it latches the entry index, the outcome and a recomputed score, then moves to S_TRAIN. With no update it stays in S_IDLE (*hold*).
- **S_TRAIN** trains the entry if needed and shifts the outcome into the history. It then always returns to S_IDLE (*commit*).

The score is recomputed at accept time, from the same weights and history a prediction would see. It therefore equals the predict-time score whenever each branch resolves before any later branch updates the block.

Top module: `perc_predictor`

## Requirements
- R1: After reset every weight is zero and every history bit is 0 (not taken). Neither a response nor busy is asserted, and any first prediction returns score 0, not taken.
- R2: A request on `pred_valid_i` is answered one cycle later on `pred_rsp_valid_o`. There is no response without a request. The score is w0 + Σ w_i·x_i, where x_i = +1 if history bit i-1 is 1 (taken) and -1 if it is 0. History bit 0 is the newest outcome.
- R3: `pred_taken_o` is 1 exactly when the score is strictly positive. A score of zero predicts not taken.
- R4: The entry is selected by the address modulo ENTRIES (its low bits). Addresses that differ by a multiple of ENTRIES share an entry.
- R5: An accepted update trains its entry only when the direction was wrong or |score| ≤ THETA. Training adds +1 to the bias if taken and -1 if not taken. It adds +1 to w_i when history bit i-1 equals the outcome, and -1 otherwise.
- R6: Weights are 8-bit two's complement and saturate at +127 and -128.
- R7: Every accepted update shifts its outcome into history bit 0, whether or not it trained. The history is unchanged in all other cycles.
- R8: An update is accepted only in S_IDLE. `upd_busy_o` is high for exactly the one cycle after an accept, and an update presented while busy is ignored.
- R9: THETA defaults to floor(1.93·HIST + 14), which is 29 for HIST = 8. A correctly predicted update whose |score| exceeds THETA leaves the weights unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pred_valid_i | input | 1 | Prediction request |
| pred_addr_i | input | AW | Branch address to predict |
| pred_rsp_valid_o | output | 1 | Response valid, one cycle after a request |
| pred_taken_o | output | 1 | Predicted direction, 1 = taken |
| pred_score_o | output | SW | Signed perceptron score |
| upd_valid_i | input | 1 | Resolved-branch update |
| upd_addr_i | input | AW | Address of the resolved branch |
| upd_taken_i | input | 1 | Actual outcome, 1 = taken |
| upd_busy_o | output | 1 | High in the training cycle; updates are ignored |

## Verification
The bound checker watches, every cycle, the one-cycle request-to-response timing, the single busy cycle after each accept, the rule that history moves only during training and then by one shifted position, and the bound on the score magnitude. The arithmetic cannot be seen by a per-cycle property. That covers the dot product, the choice of which updates train, saturation at the weight limits and entry aliasing. Only the bench's reference model and scenarios show these: repeated taken runs past the threshold, mispredictions, addresses that alias, updates ignored while busy, and long runs against a second instance with a very high threshold that drive weights into both limits.

// File: rtl/perc_pkg.sv
package perc_pkg;

    // Update controller states
    typedef enum logic [0:0] {
        S_IDLE  = 1'b0,
        S_TRAIN = 1'b1
    } upd_state_e;

    // Default training threshold: floor(1.93*h + 14), in integer arithmetic
    function automatic int theta_default(input int h);
        return (193 * h + 1400) / 100;
    endfunction

endpackage

// File: rtl/perc_dot.sv
// Combinational perceptron score: bias plus signed history-weighted sum.
module perc_dot #(
    parameter int HIST  = 8,
    parameter int WBITS = 8,
    parameter int SW    = 13
) (
    input  logic [(HIST+1)*WBITS-1:0] row_i,
    input  logic [HIST-1:0]           hist_i,
    output logic signed [SW-1:0]      score_o
);

    always_comb begin
        logic signed [WBITS-1:0] w;
        logic signed [SW-1:0]    acc;
        w   = row_i[WBITS-1:0];
        acc = SW'(w);
        for (int i = 1; i <= HIST; i++) begin
            w = row_i[i*WBITS +: WBITS];
            if (hist_i[i-1]) acc = acc + SW'(w);
            else             acc = acc - SW'(w);
        end
        score_o = acc;
    end

endmodule

// File: rtl/perc_table.sv
// Weight storage: two read rows, one trained row written per commit.
module perc_table #(
    parameter int ENTRIES = 8,
    parameter int HIST    = 8,
    parameter int WBITS   = 8,
    localparam int IDXW   = $clog2(ENTRIES),
    localparam int ROWW   = (HIST + 1) * WBITS
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [IDXW-1:0] rd_a_idx_i,
    output logic [ROWW-1:0] rd_a_row_o,
    input  logic [IDXW-1:0] rd_b_idx_i,
    output logic [ROWW-1:0] rd_b_row_o,
    input  logic            wr_en_i,
    input  logic [IDXW-1:0] wr_idx_i,
    input  logic            wr_taken_i,
    input  logic [HIST-1:0] wr_hist_i
);

    localparam logic signed [WBITS-1:0] W_MAX = {1'b0, {(WBITS-1){1'b1}}};
    localparam logic signed [WBITS-1:0] W_MIN = {1'b1, {(WBITS-1){1'b0}}};

    logic [ROWW-1:0] rows_q [ENTRIES];
    logic [ROWW-1:0] cur_row;
    logic [ROWW-1:0] new_row;

    assign rd_a_row_o = rows_q[rd_a_idx_i];
    assign rd_b_row_o = rows_q[rd_b_idx_i];
    assign cur_row    = rows_q[wr_idx_i];

    // One saturating lane per weight; lane 0 is the bias (input fixed at +1)
    for (genvar k = 0; k <= HIST; k++) begin : g_lane
        logic signed [WBITS-1:0] w_old;
        logic                    go_up;
        assign w_old = cur_row[k*WBITS +: WBITS];
        if (k == 0) begin : g_bias
            assign go_up = wr_taken_i;
        end else begin : g_hist
            assign go_up = (wr_hist_i[k-1] == wr_taken_i);
        end
        always_comb begin
            if (go_up) begin
                new_row[k*WBITS +: WBITS] = (w_old == W_MAX) ? w_old : w_old + 1'b1;
            end else begin
                new_row[k*WBITS +: WBITS] = (w_old == W_MIN) ? w_old : w_old - 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int e = 0; e < ENTRIES; e++) rows_q[e] <= '0;
        end else if (wr_en_i) begin
            rows_q[wr_idx_i] <= new_row;
        end
    end

endmodule

// File: rtl/perc_history.sv
// Global outcome history, newest outcome in bit 0.
module perc_history #(
    parameter int HIST = 8
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            shift_i,
    input  logic            bit_i,
    output logic [HIST-1:0] hist_o
);

    logic [HIST-1:0] hist_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      hist_q <= '0;
        else if (shift_i) hist_q <= {hist_q[HIST-2:0], bit_i};
    end

    assign hist_o = hist_q;

endmodule

// File: rtl/perc_predictor.sv
module perc_predictor
    import perc_pkg::*;
#(
    parameter int  ENTRIES = 8,
    parameter int  HIST    = 8,
    parameter int  WBITS   = 8,
    parameter int  AW      = 32,
    parameter int  THETA   = theta_default(HIST),
    localparam int SW      = WBITS + $clog2(HIST + 1) + 1
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 pred_valid_i,
    input  logic [AW-1:0]        pred_addr_i,
    output logic                 pred_rsp_valid_o,
    output logic                 pred_taken_o,
    output logic signed [SW-1:0] pred_score_o,
    input  logic                 upd_valid_i,
    input  logic [AW-1:0]        upd_addr_i,
    input  logic                 upd_taken_i,
    output logic                 upd_busy_o
);

    localparam int IDXW  = $clog2(ENTRIES);
    localparam int ROWW  = (HIST + 1) * WBITS;
    localparam int MAXSC = (HIST + 1) * (2 ** (WBITS - 1));
    localparam int THR_C = (THETA > MAXSC) ? MAXSC : THETA;
    localparam logic signed [SW-1:0] THR = SW'(THR_C);

    upd_state_e state_q, state_d;

    logic [IDXW-1:0]        pred_idx, upd_idx;
    logic [ROWW-1:0]        pred_row, upd_row;
    logic signed [SW-1:0]   pred_score, upd_score;
    logic [HIST-1:0]        ghist;

    logic [IDXW-1:0]        lat_idx_q;
    logic                   lat_taken_q;
    logic signed [SW-1:0]   lat_score_q;

    logic                   accept;
    logic                   in_train;
    logic                   dir_wrong;
    logic                   low_conf;
    logic                   train_en;
    logic                   addr_unused;

    assign pred_idx    = pred_addr_i[IDXW-1:0];
    assign upd_idx     = upd_addr_i[IDXW-1:0];
    assign addr_unused = ^{pred_addr_i[AW-1:IDXW], upd_addr_i[AW-1:IDXW]};

    // Storage and the two score datapaths
    perc_table #(
        .ENTRIES(ENTRIES), .HIST(HIST), .WBITS(WBITS)
    ) u_table (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .rd_a_idx_i (pred_idx),
        .rd_a_row_o (pred_row),
        .rd_b_idx_i (upd_idx),
        .rd_b_row_o (upd_row),
        .wr_en_i    (train_en),
        .wr_idx_i   (lat_idx_q),
        .wr_taken_i (lat_taken_q),
        .wr_hist_i  (ghist)
    );

    perc_dot #(.HIST(HIST), .WBITS(WBITS), .SW(SW)) u_dot_pred (
        .row_i   (pred_row),
        .hist_i  (ghist),
        .score_o (pred_score)
    );

    perc_dot #(.HIST(HIST), .WBITS(WBITS), .SW(SW)) u_dot_upd (
        .row_i   (upd_row),
        .hist_i  (ghist),
        .score_o (upd_score)
    );

    perc_history #(.HIST(HIST)) u_hist (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .shift_i (in_train),
        .bit_i   (lat_taken_q),
        .hist_o  (ghist)
    );

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= S_IDLE;
        else         state_q <= state_d;
    end

    // Next state: accept, hold, commit
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (upd_valid_i) state_d = S_TRAIN;
            S_TRAIN: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    assign accept   = (state_q == S_IDLE) && upd_valid_i;
    assign in_train = (state_q == S_TRAIN);

    // Latch of the accepted update and its recomputed score
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lat_idx_q   <= '0;
            lat_taken_q <= 1'b0;
            lat_score_q <= '0;
        end else if (accept) begin
            lat_idx_q   <= upd_idx;
            lat_taken_q <= upd_taken_i;
            lat_score_q <= upd_score;
        end
    end

    // Thresholded training decision
    assign dir_wrong = (lat_score_q > 0) != lat_taken_q;
    assign low_conf  = (lat_score_q <= THR) && (lat_score_q >= -THR);
    assign train_en  = in_train && (dir_wrong || low_conf);

    // Outputs
    assign upd_busy_o = in_train;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pred_rsp_valid_o <= 1'b0;
            pred_taken_o     <= 1'b0;
            pred_score_o     <= '0;
        end else begin
            pred_rsp_valid_o <= pred_valid_i;
            if (pred_valid_i) begin
                pred_taken_o <= (pred_score > 0);
                pred_score_o <= pred_score;
            end
        end
    end

endmodule

// File: rtl/perc_checker.sv
module perc_checker #(
    parameter int HIST  = 8,
    parameter int WBITS = 8,
    parameter int SW    = 13
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic                 pred_valid_i,
    input logic                 pred_rsp_valid_o,
    input logic signed [SW-1:0] pred_score_o,
    input logic                 upd_valid_i,
    input logic                 upd_busy_o,
    input logic [HIST-1:0]      hist_i
);

    localparam int MAXSC = (HIST + 1) * (2 ** (WBITS - 1));
    localparam logic signed [SW-1:0] SC_MAX = SW'(MAXSC);

    p_rsp_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pred_valid_i |=> pred_rsp_valid_o);

    p_no_spurious_rsp_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pred_valid_i |=> !pred_rsp_valid_o);

    p_accept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (upd_valid_i && !upd_busy_o) |=> upd_busy_o);

    p_busy_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        upd_busy_o |=> !upd_busy_o);

    p_hist_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !upd_busy_o |=> $stable(hist_i));

    p_hist_shift_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        upd_busy_o |=> (hist_i[HIST-1:1] == $past(hist_i[HIST-2:0])));

    p_score_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pred_rsp_valid_o |-> ((pred_score_o <= SC_MAX) && (pred_score_o >= -SC_MAX)));

endmodule

bind perc_predictor perc_checker #(
    .HIST(HIST), .WBITS(WBITS), .SW(SW)
) u_perc_checker (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .pred_valid_i     (pred_valid_i),
    .pred_rsp_valid_o (pred_rsp_valid_o),
    .pred_score_o     (pred_score_o),
    .upd_valid_i      (upd_valid_i),
    .upd_busy_o       (upd_busy_o),
    .hist_i           (ghist)
);

// File: tb/test_perc_predictor.sv
module test_perc_predictor;

    localparam int CLK_PERIOD = 10;
    localparam int ENTRIES    = 8;
    localparam int H          = 8;
    localparam int AW         = 32;
    localparam int SW         = 8 + $clog2(H + 1) + 1;
    localparam int THETA      = 29;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic                 pred_valid = 1'b0;
    logic [AW-1:0]        pred_addr  = '0;
    logic                 rsp_valid, rsp_taken;
    logic signed [SW-1:0] rsp_score;
    logic                 upd_valid  = 1'b0;
    logic [AW-1:0]        upd_addr   = '0;
    logic                 upd_taken  = 1'b0;
    logic                 busy;

    logic                 s_pred_valid = 1'b0;
    logic                 s_upd_valid  = 1'b0;
    logic                 s_upd_taken  = 1'b0;
    logic                 s_rsp_valid, s_rsp_taken, s_busy;
    logic signed [SW-1:0] s_rsp_score;

    perc_predictor i_perc_predictor (
        .clk_i(clk), .rst_ni(rst_n),
        .pred_valid_i(pred_valid), .pred_addr_i(pred_addr),
        .pred_rsp_valid_o(rsp_valid), .pred_taken_o(rsp_taken), .pred_score_o(rsp_score),
        .upd_valid_i(upd_valid), .upd_addr_i(upd_addr), .upd_taken_i(upd_taken),
        .upd_busy_o(busy)
    );

    // Second instance with a threshold high enough that every update trains
    perc_predictor #(.THETA(4000)) i_perc_predictor_sat (
        .clk_i(clk), .rst_ni(rst_n),
        .pred_valid_i(s_pred_valid), .pred_addr_i('0),
        .pred_rsp_valid_o(s_rsp_valid), .pred_taken_o(s_rsp_taken), .pred_score_o(s_rsp_score),
        .upd_valid_i(s_upd_valid), .upd_addr_i('0), .upd_taken_i(s_upd_taken),
        .upd_busy_o(s_busy)
    );

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int  mw [ENTRIES][H+1];
    bit  hq [$];            // hq[0] is the newest outcome
    bit  m_busy;
    int  m_idx;
    bit  m_taken;
    int  m_score;
    bit  e_rsp;
    bit  e_taken;
    int  e_score;

    function automatic int mscore(input int e);
        int s;
        s = mw[e][0];
        for (int i = 1; i <= H; i++) s += hq[i-1] ? mw[e][i] : -mw[e][i];
        return s;
    endfunction

    function automatic int clamp(input int v);
        if (v > 127)  return 127;
        if (v < -128) return -128;
        return v;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++)
                for (int k = 0; k <= H; k++) mw[e][k] = 0;
            hq.delete();
            for (int i = 0; i < H; i++) hq.push_back(1'b0);
            m_busy = 1'b0; e_rsp = 1'b0; e_taken = 1'b0; e_score = 0;
        end else begin
            e_rsp = pred_valid;
            if (pred_valid) begin
                e_score = mscore(int'(pred_addr % ENTRIES));
                e_taken = (e_score > 0);
            end
            if (m_busy) begin
                if (((m_score > 0) != m_taken) || (m_score <= THETA && m_score >= -THETA)) begin
                    mw[m_idx][0] = clamp(mw[m_idx][0] + (m_taken ? 1 : -1));
                    for (int i = 1; i <= H; i++)
                        mw[m_idx][i] = clamp(mw[m_idx][i] + ((hq[i-1] == m_taken) ? 1 : -1));
                end
                hq.push_front(m_taken);
                void'(hq.pop_back());
                m_busy = 1'b0;
            end else if (upd_valid) begin
                m_idx   = int'(upd_addr % ENTRIES);
                m_taken = upd_taken;
                m_score = mscore(m_idx);
                m_busy  = 1'b1;
            end
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(rsp_valid == e_rsp, "R2 rsp_valid", rsp_valid, e_rsp);
            chk(busy == m_busy, "R8 busy", busy, m_busy);
            if (e_rsp) begin
                chk(int'(rsp_score) == e_score, "R2 score", int'(rsp_score), e_score);
                chk(rsp_taken == e_taken, "R3 direction", rsp_taken, e_taken);
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic predict(input int a, output int sc, output bit tk);
        @(negedge clk);
        pred_valid = 1'b1; pred_addr = AW'(a);
        @(negedge clk);
        pred_valid = 1'b0;
        sc = int'(rsp_score);
        tk = rsp_taken;
    endtask

    task automatic update(input int a, input bit t);
        @(negedge clk);
        upd_valid = 1'b1; upd_addr = AW'(a); upd_taken = t;
        @(negedge clk);
        upd_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic s_hold(input bit t, input int cycles);
        @(negedge clk);
        s_upd_valid = 1'b1; s_upd_taken = t;
        repeat (cycles) @(negedge clk);
        s_upd_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic s_predict(output int sc, output bit tk);
        @(negedge clk);
        s_pred_valid = 1'b1;
        @(negedge clk);
        s_pred_valid = 1'b0;
        sc = int'(s_rsp_score);
        tk = s_rsp_taken;
    endtask

    initial begin
        int sc, s1, s2;
        bit tk;
        repeat (3) @(negedge clk);
        // R1: reset state seen at the ports
        chk(rsp_valid == 1'b0, "R1 rsp after reset", rsp_valid, 0);
        chk(busy == 1'b0, "R1 busy after reset", busy, 0);
        rst_n = 1'b1;
        for (int e = 0; e < ENTRIES; e++) begin
            predict(e, sc, tk);
            chk(sc == 0, "R1 zero weights", sc, 0);
            chk(tk == 1'b0, "R3 zero score not taken", tk, 0);
        end

        // R5/R7: first training of entry 3 from zero state
        update(3, 1'b1);
        predict(3, sc, tk);
        chk(sc == 7, "R5 trained score", sc, 7);
        chk(tk == 1'b1, "R3 positive taken", tk, 1);
        // R4: aliasing address and a neighbour entry
        predict(3 + ENTRIES, sc, tk);
        chk(sc == 7, "R4 alias shares entry", sc, 7);
        predict(3 + 5 * ENTRIES, sc, tk);
        chk(sc == 7, "R4 modulo select", sc, 7);
        predict(2, sc, tk);
        chk(sc == 0, "R4 other entry untouched", sc, 0);

        // R8: update presented during busy is ignored
        @(negedge clk);
        upd_valid = 1'b1; upd_addr = 5; upd_taken = 1'b1;
        @(negedge clk);
        chk(busy == 1'b1, "R8 busy after accept", busy, 1);
        upd_addr = 6;
        @(negedge clk);
        upd_valid = 1'b0;
        chk(busy == 1'b0, "R8 busy one cycle", busy, 0);
        @(negedge clk);
        predict(6, sc, tk);
        chk(sc == 0, "R8 ignored update", sc, 0);

        // R9: confident correct update leaves weights unchanged
        for (int i = 0; i < 24; i++) update(4, 1'b1);
        predict(4, s1, tk);
        chk(s1 > THETA, "R9 above threshold", s1, THETA + 1);
        update(4, 1'b1);
        predict(4, s2, tk);
        chk(s2 == s1, "R9 no training when confident", s2, s1);
        // R5: misprediction trains (checked against model each cycle)
        update(4, 1'b0);
        for (int i = 0; i < 3; i++) update(4, 1'b1);
        predict(4, sc, tk);

        // Mixed pattern with predictions overlapping updates
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            upd_valid = 1'b1; upd_addr = AW'(i * 3); upd_taken = (i % 3 == 0);
            pred_valid = 1'b1; pred_addr = AW'(i * 5 + 1);
            @(negedge clk);
            upd_valid = 1'b0; pred_valid = 1'b0;
            @(negedge clk);
        end

        // R6: saturation in the always-training instance
        s_hold(1'b1, 280);
        s_predict(sc, tk);
        chk(sc == 1139, "R6 saturate at +127", sc, 1139);
        chk(tk == 1'b1, "R3 saturated taken", tk, 1);
        s_hold(1'b0, 800);
        s_predict(sc, tk);
        chk(sc == -1144, "R6 saturate at -128", sc, -1144);
        chk(tk == 1'b0, "R3 negative not taken", tk, 0);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule